// File: doc/BRIEF.md
# CAN Transmit Mailbox Status Controller

This block keeps the transmit-side control and status flags for a bank of message slots in a CAN controller. Software sets and clears a per-slot transmit request and clears per-slot sent flags. The block picks one requesting slot when the bus is idle and hands it to an abstract bus engine. It then tracks which slot is in flight, which slots have sent, whether the node is currently the transmitter, the number of the last slot that sent successfully, and a success interrupt.

The engine is modelled by strobes only. The block issues a start pulse with a slot number. The engine answers with an arbitration-lost strobe or a transmission-done strobe. Bit timing, framing, CRC, stuffing, error confinement and reception live elsewhere. Software may re-send a slot only after it has cleared that slot's sent and request flags, seen both read back as 0, and then set the request again.

Top module: `can_tx_mbox_ctrl`

## Requirements
- R1: After reset, every request, active and sent flag is 0, and transmitter state, success flag, last-slot field, interrupt and start pulse are all 0.
- R2: A grant happens only in a cycle where `bus_idle_i` is 1 and `trm_state_o` is 0. On the next edge the granted slot's bit in `tx_active_o` becomes 1, `trm_state_o` becomes 1, and `tx_start_o` pulses for one cycle with the slot number on `tx_slot_o`. While the bus is not idle, a pending request starts nothing.
- R3: Among eligible slots the lowest number wins. At most one bit of `tx_active_o` is 1, and `bus_idle_i` during a transmission grants nothing more.
- R4: A slot is eligible only if its request bit is 1, its sent bit is 0 and its active bit is 0. A slot whose sent bit is 1 is never granted.
- R5: `arb_lost_i` during a transmission clears the slot's active bit and `trm_state_o`. The slot's request bit stays at 1, so the slot is granted again at the next bus idle.
- R6: `tx_done_i` without `arb_lost_i` during a transmission sets the slot's sent bit, clears its active bit and clears `trm_state_o`.
- R7: A success loads `last_slot_o` (4 bits for 16 slots) with the slot number and sets `trm_succ_o`. `last_slot_o` holds until the next success. `trm_succ_o` clears when the next transmission starts.
- R8: On a success, `irq_o` is a one-cycle pulse, and only when `irq_en_i` was 1 in the success cycle.
- R9: `tx_done_i` and `arb_lost_i` have no effect while `trm_state_o` is 0. When both come in the same cycle, the outcome is treated as a lost arbitration.
- R10: `req_set_i` and `req_clr_i` set and clear request bits per slot, and clear wins when both are 1. `sent_clr_i` clears sent bits per slot. After clearing sent and request, a new request set makes the slot eligible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | 16 | Per-slot transmit request set pulse |
| req_clr_i | input | 16 | Per-slot transmit request clear pulse (wins over set) |
| sent_clr_i | input | 16 | Per-slot sent flag clear pulse |
| irq_en_i | input | 1 | Success interrupt enable |
| bus_idle_i | input | 1 | Bus is idle; a grant may occur |
| arb_lost_i | input | 1 | Engine strobe: arbitration lost |
| tx_done_i | input | 1 | Engine strobe: frame sent successfully |
| tx_start_o | output | 1 | One-cycle start pulse to the engine |
| tx_slot_o | output | 4 | Slot number being sent |
| tx_req_o | output | 16 | Transmit request flags |
| tx_active_o | output | 16 | Transmit active flags |
| sent_o | output | 16 | Sent flags |
| trm_state_o | output | 1 | Node is transmitter |
| trm_succ_o | output | 1 | Last transmission succeeded |
| last_slot_o | output | 4 | Number of the last slot that sent |
| irq_o | output | 1 | Success interrupt pulse |

## Verification
The assertions check on every cycle that at most one slot is active and that this agrees with the transmitter state. They also check that the start pulse needs a prior idle bus and a slot that had not sent, that the interrupt is a single pulse gated by its enable, and that the last-slot field changes only together with a fresh success. Only the bench scenarios can show the lowest-number choice among several requesters, re-grant after lost arbitration, the exact values loaded into the last-slot field, and the full clear-then-re-request sequence. The same holds for the handling of simultaneous lost and done strobes and for slot 15 at the top of the range.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  localparam int unsigned DEF_SLOTS = 16;

  // outcome of the frame in flight, as seen by the bank
  typedef struct packed {
    logic lost;
    logic done;
  } tx_evt_t;
endpackage

// File: rtl/can_tx_slot_bank.sv
module can_tx_slot_bank #(
  parameter int unsigned NUM_SLOTS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] req_set_i,
  input  logic [NUM_SLOTS-1:0] req_clr_i,
  input  logic [NUM_SLOTS-1:0] sent_clr_i,
  input  logic [NUM_SLOTS-1:0] grant_oh_i,
  input  logic [NUM_SLOTS-1:0] cur_oh_i,
  input  can_tx_pkg::tx_evt_t  evt_i,
  output logic [NUM_SLOTS-1:0] req_o,
  output logic [NUM_SLOTS-1:0] active_o,
  output logic [NUM_SLOTS-1:0] sent_o,
  output logic [NUM_SLOTS-1:0] elig_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic req_q, act_q, sent_q;
    logic done_hit, lost_hit;

    assign done_hit = evt_i.done & cur_oh_i[g];
    assign lost_hit = evt_i.lost & cur_oh_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q  <= 1'b0;
        act_q  <= 1'b0;
        sent_q <= 1'b0;
      end else begin
        if (req_clr_i[g])      req_q <= 1'b0;
        else if (req_set_i[g]) req_q <= 1'b1;

        if (grant_oh_i[g])               act_q <= 1'b1;
        else if (done_hit || lost_hit)   act_q <= 1'b0;

        if (done_hit)           sent_q <= 1'b1;
        else if (sent_clr_i[g]) sent_q <= 1'b0;
      end
    end

    assign req_o[g]    = req_q;
    assign active_o[g] = act_q;
    assign sent_o[g]   = sent_q;
    assign elig_o[g]   = req_q & ~sent_q & ~act_q;
  end
endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter #(
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] elig_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [NUM_SLOTS-1:0] oh_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (elig_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |elig_i;
  assign oh_o    = elig_i & (~elig_i + NUM_SLOTS'(1));
endmodule

// File: rtl/can_tx_status.sv
module can_tx_status #(
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                grant_go_i,
  input  logic [IDX_W-1:0]    grant_idx_i,
  input  logic                arb_lost_i,
  input  logic                tx_done_i,
  input  logic                irq_en_i,
  output can_tx_pkg::tx_evt_t evt_o,
  output logic [IDX_W-1:0]    cur_idx_o,
  output logic                start_o,
  output logic                state_o,
  output logic                succ_o,
  output logic [IDX_W-1:0]    last_o,
  output logic                irq_o
);
  logic             state_q, succ_q, start_q, irq_q;
  logic [IDX_W-1:0] cur_q, last_q;

  // strobes count only while a frame is in flight; lost beats done
  assign evt_o.lost = state_q & arb_lost_i;
  assign evt_o.done = state_q & tx_done_i & ~arb_lost_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      succ_q  <= 1'b0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      cur_q   <= '0;
      last_q  <= '0;
    end else begin
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      if (grant_go_i) begin
        state_q <= 1'b1;
        cur_q   <= grant_idx_i;
        succ_q  <= 1'b0;
        start_q <= 1'b1;
      end else if (evt_o.lost) begin
        state_q <= 1'b0;
      end else if (evt_o.done) begin
        state_q <= 1'b0;
        last_q  <= cur_q;
        succ_q  <= 1'b1;
        irq_q   <= irq_en_i;
      end
    end
  end

  assign cur_idx_o = cur_q;
  assign start_o   = start_q;
  assign state_o   = state_q;
  assign succ_o    = succ_q;
  assign last_o    = last_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/can_tx_mbox_ctrl.sv
module can_tx_mbox_ctrl #(
  parameter int unsigned NUM_SLOTS = can_tx_pkg::DEF_SLOTS,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] req_set_i,
  input  logic [NUM_SLOTS-1:0] req_clr_i,
  input  logic [NUM_SLOTS-1:0] sent_clr_i,
  input  logic                 irq_en_i,
  input  logic                 bus_idle_i,
  input  logic                 arb_lost_i,
  input  logic                 tx_done_i,
  output logic                 tx_start_o,
  output logic [IDX_W-1:0]     tx_slot_o,
  output logic [NUM_SLOTS-1:0] tx_req_o,
  output logic [NUM_SLOTS-1:0] tx_active_o,
  output logic [NUM_SLOTS-1:0] sent_o,
  output logic                 trm_state_o,
  output logic                 trm_succ_o,
  output logic [IDX_W-1:0]     last_slot_o,
  output logic                 irq_o
);
  logic [NUM_SLOTS-1:0] elig, pick_oh, grant_oh, cur_oh;
  logic                 pick_valid, grant_go;
  logic [IDX_W-1:0]     pick_idx, cur_idx;
  can_tx_pkg::tx_evt_t  evt;

  can_tx_arbiter #(.NUM_SLOTS(NUM_SLOTS)) arb_i (
    .elig_i (elig),
    .valid_o(pick_valid),
    .idx_o  (pick_idx),
    .oh_o   (pick_oh)
  );

  assign grant_go = bus_idle_i & ~trm_state_o & pick_valid;
  assign grant_oh = grant_go ? pick_oh : '0;
  assign cur_oh   = NUM_SLOTS'(1) << cur_idx;

  can_tx_status #(.NUM_SLOTS(NUM_SLOTS)) stat_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_go_i (grant_go),
    .grant_idx_i(pick_idx),
    .arb_lost_i (arb_lost_i),
    .tx_done_i  (tx_done_i),
    .irq_en_i   (irq_en_i),
    .evt_o      (evt),
    .cur_idx_o  (cur_idx),
    .start_o    (tx_start_o),
    .state_o    (trm_state_o),
    .succ_o     (trm_succ_o),
    .last_o     (last_slot_o),
    .irq_o      (irq_o)
  );

  can_tx_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) bank_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_set_i (req_set_i),
    .req_clr_i (req_clr_i),
    .sent_clr_i(sent_clr_i),
    .grant_oh_i(grant_oh),
    .cur_oh_i  (cur_oh),
    .evt_i     (evt),
    .req_o     (tx_req_o),
    .active_o  (tx_active_o),
    .sent_o    (sent_o),
    .elig_o    (elig)
  );

  assign tx_slot_o = cur_idx;
endmodule

// File: rtl/can_tx_mbox_ctrl_chk.sv
module can_tx_mbox_ctrl_chk #(
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 irq_en_i,
  input logic                 bus_idle_i,
  input logic                 arb_lost_i,
  input logic                 tx_done_i,
  input logic                 tx_start_o,
  input logic [IDX_W-1:0]     tx_slot_o,
  input logic [NUM_SLOTS-1:0] tx_active_o,
  input logic [NUM_SLOTS-1:0] sent_o,
  input logic                 trm_state_o,
  input logic                 trm_succ_o,
  input logic [IDX_W-1:0]     last_slot_o,
  input logic                 irq_o
);
  a_r3_one_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_active_o));

  a_r2_state_tracks_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trm_state_o == (tx_active_o != '0));

  a_r2_start_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(bus_idle_i) && !$past(trm_state_o));

  a_r4_start_not_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> !sent_o[tx_slot_o] && tx_active_o[tx_slot_o]);

  a_r8_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r8_irq_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i) && trm_succ_o);

  a_r7_last_moves_on_success: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(last_slot_o) |-> $rose(trm_succ_o));

  a_r6_done_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trm_state_o && tx_done_i && !arb_lost_i) |=> !trm_state_o && trm_succ_o);

  a_r5_lost_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trm_state_o && arb_lost_i) |=> !trm_state_o && $stable(sent_o));
endmodule

bind can_tx_mbox_ctrl can_tx_mbox_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_en_i   (irq_en_i),
  .bus_idle_i (bus_idle_i),
  .arb_lost_i (arb_lost_i),
  .tx_done_i  (tx_done_i),
  .tx_start_o (tx_start_o),
  .tx_slot_o  (tx_slot_o),
  .tx_active_o(tx_active_o),
  .sent_o     (sent_o),
  .trm_state_o(trm_state_o),
  .trm_succ_o (trm_succ_o),
  .last_slot_o(last_slot_o),
  .irq_o      (irq_o)
);

// File: tb/can_tx_mbox_ctrl_tb_top.sv
module can_tx_mbox_ctrl_tb_top;
  localparam int N = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_set_i = '0, req_clr_i = '0, sent_clr_i = '0;
  logic          irq_en_i = 1'b0, bus_idle_i = 1'b0, arb_lost_i = 1'b0, tx_done_i = 1'b0;
  logic          tx_start_o, trm_state_o, trm_succ_o, irq_o;
  logic [3:0]    tx_slot_o, last_slot_o;
  logic [N-1:0]  tx_req_o, tx_active_o, sent_o;

  int errors = 0;
  int checks = 0;
  int exp_start[$];
  bit done_flag = 1'b0;

  always #2 clk_i = ~clk_i;

  can_tx_mbox_ctrl dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  // driver: queue expected start slot, open one idle window
  task automatic grant(int slot);
    exp_start.push_back(slot);
    bus_idle_i = 1'b1;
    step();
    bus_idle_i = 1'b0;
  endtask

  task automatic done_pulse(logic en, logic lost);
    irq_en_i = en; tx_done_i = 1'b1; arb_lost_i = lost;
    step();
    tx_done_i = 1'b0; arb_lost_i = 1'b0;
  endtask

  // monitor: every start pulse must match the queued slot
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && tx_start_o) begin
      if (exp_start.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected start actual=%0d expected=none", tx_slot_o);
      end else begin
        check("R3 start slot", 32'(tx_slot_o), 32'(exp_start.pop_front()));
      end
    end
  end

  initial begin
    #100000;
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    check("R1 req", 32'(tx_req_o), 0);
    check("R1 active", 32'(tx_active_o), 0);
    check("R1 sent", 32'(sent_o), 0);
    check("R1 misc", {tx_start_o, trm_state_o, trm_succ_o, irq_o, last_slot_o}, 0);
    rst_ni = 1'b1;
    step();

    // R10/R2: requests pending, bus busy -> nothing starts
    req_set_i = (N'(1) << 5) | (N'(1) << 2);
    step(); req_set_i = '0; step();
    check("R10 req set", 32'(tx_req_o), 32'h24);
    check("R2 busy no start", {31'd0, trm_state_o}, 0);

    // R3 lowest wins
    grant(2);
    check("R2 active", 32'(tx_active_o), 32'h4);
    check("R2 state", {31'd0, trm_state_o}, 1);
    bus_idle_i = 1'b1; step(); bus_idle_i = 1'b0;
    check("R3 no second grant", 32'(tx_active_o), 32'h4);

    // R6/R7/R8 success with irq enabled
    done_pulse(1'b1, 1'b0);
    check("R6 sent", 32'(sent_o), 32'h4);
    check("R6 active", 32'(tx_active_o), 0);
    check("R6 state", {31'd0, trm_state_o}, 0);
    check("R7 last", 32'(last_slot_o), 2);
    check("R7 succ", {31'd0, trm_succ_o}, 1);
    check("R8 irq", {31'd0, irq_o}, 1);
    step();
    check("R8 irq pulse", {31'd0, irq_o}, 0);

    // R4 slot 2 sent -> slot 5 chosen; R7 succ clears at start
    grant(5);
    check("R4 skip sent", 32'(tx_active_o), 32'h20);
    check("R7 succ cleared", {31'd0, trm_succ_o}, 0);
    check("R7 last held", 32'(last_slot_o), 2);

    // R5 lost
    arb_lost_i = 1'b1; step(); arb_lost_i = 1'b0;
    check("R5 active", 32'(tx_active_o), 0);
    check("R5 state", {31'd0, trm_state_o}, 0);
    check("R5 req kept", 32'(tx_req_o), 32'h24);
    check("R5 last", 32'(last_slot_o), 2);
    grant(5);
    check("R5 regrant", 32'(tx_active_o), 32'h20);

    // R8 no irq when disabled
    done_pulse(1'b0, 1'b0);
    check("R8 irq gated", {31'd0, irq_o}, 0);
    check("R7 last 5", 32'(last_slot_o), 5);
    check("R6 sent both", 32'(sent_o), 32'h24);

    // R9 strobes ignored when idle
    irq_en_i = 1'b1;
    done_pulse(1'b1, 1'b0);
    check("R9 sent kept", 32'(sent_o), 32'h24);
    check("R9 irq", {31'd0, irq_o}, 0);
    check("R9 last", 32'(last_slot_o), 5);
    bus_idle_i = 1'b1; step(); bus_idle_i = 1'b0;
    check("R4 none eligible", {31'd0, trm_state_o}, 0);

    // R10 clear-then-rerequest on slot 2
    sent_clr_i = N'(1) << 2; req_clr_i = N'(1) << 2;
    step(); sent_clr_i = '0; req_clr_i = '0;
    check("R10 req clr", 32'(tx_req_o), 32'h20);
    check("R10 sent clr", 32'(sent_o), 32'h20);
    req_set_i = N'(1) << 2; req_clr_i = N'(1) << 2;
    step(); req_set_i = '0; req_clr_i = '0;
    check("R10 clr wins", 32'(tx_req_o), 32'h20);
    req_set_i = N'(1) << 2; step(); req_set_i = '0;
    grant(2);
    check("R10 regrant", 32'(tx_active_o), 32'h4);

    // R9 lost and done together -> lost
    done_pulse(1'b1, 1'b1);
    check("R9 both active", 32'(tx_active_o), 0);
    check("R9 both sent", 32'(sent_o), 32'h20);
    check("R9 both last", 32'(last_slot_o), 5);
    check("R9 both irq", {31'd0, irq_o}, 0);
    grant(2);
    done_pulse(1'b1, 1'b0);
    check("R7 last 2", 32'(last_slot_o), 2);

    // top slot
    req_set_i = N'(1) << 15; step(); req_set_i = '0;
    grant(15);
    done_pulse(1'b1, 1'b0);
    check("R7 last 15", 32'(last_slot_o), 15);
    check("R8 irq 15", {31'd0, irq_o}, 1);
    check("R6 sent 15", 32'(sent_o), 32'h8024);

    step();
    check("R2 all starts seen", 32'(exp_start.size()), 0);
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule